// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port for a chip's boundary-scan logic. A tester drives a test clock, a mode-select line and serial data; the block walks the standard sixteen-state port state machine, holds a four-bit instruction, and routes one of three data registers between serial in and serial out. The registers are a one-cell bypass register, a fixed 32-bit identification word and a boundary chain whose length and update cells are parameters.

Toward the core it reports which data register is selected, and it raises three requests: float all three-state outputs, drive outputs from the boundary update latches, and start a self-test. Beside the standard scan instructions the opcode map has two bypass-style instructions (one floats the outputs, one holds them from the latches) and one private self-test code. Pad drivers and the self-test engine live outside.

Top module: `tap_ctrl`

## Requirements
- R1: Test-Logic-Reset is entered on any rising test-clock edge that samples `trst_n` low, and after five rising edges in a row that sample `tms` high. In that state the instruction becomes 0001, `dr_sel` reads 01 and the three core requests are low. Only `trst_n` also clears `bnd_drive` to zero.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads the pattern 0001, so the first bit out in Shift-IR is 1 and the next three are 0.
- R3: `dr_sel` encodes the selected data register: 00 bypass, 01 identification, 10 boundary. Opcode 0001 selects identification. Opcodes 0000, 0010 and 0101 select boundary. Opcodes 0011, 0100 and every code 0110 to 1111 select bypass.
- R4: With identification selected, Capture-DR loads 32'h39400003 (version 0011, part 1001010000000000, maker 00000000001, bit 0 set). It shifts out LSB first, and is followed by the bits shifted in.
- R5: The bypass register is one cell. It captures 0, so a DR scan returns 0 and then the input delayed by one bit.
- R6: With boundary selected, Capture-DR loads `bnd_pins_in`, and cell 0 is the cell nearest TDO. On the falling edge in Update-DR, each cell whose bit in the update mask is 1 copies its shift stage to `bnd_drive`. Cells whose mask bit is 0 read 0.
- R7: `core_hiz` is high only for opcode 0011, which also selects bypass.
- R8: `core_hold` is high for opcodes 0000 and 0100. While a bypass instruction is active, DR scans leave `bnd_drive` unchanged.
- R9: `selftest_req` is high only for opcode 0101, which selects the boundary chain.
- R10: A new instruction, and so every decoded output, changes only on the falling test-clock edge in Update-IR or in Test-Logic-Reset. On the rising edge that enters Update-IR the old values still hold.
- R11: `tdo` changes on falling edges only. `tdo_oe` is high only during Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Enable for the serial-out driver |
| dr_sel | output | 2 | Selected data register (00 bypass, 01 ident, 10 boundary) |
| core_hiz | output | 1 | Request to float all three-state core outputs |
| core_hold | output | 1 | Request to drive core outputs from `bnd_drive` |
| selftest_req | output | 1 | Request to run the core self-test |
| bnd_pins_in | input | BND_LEN | Values captured into the boundary chain |
| bnd_drive | output | BND_LEN | Boundary update latches |

## Verification
Decoded outputs are due half a test clock after the rising edge that enters Update-IR or Test-Logic-Reset. Update latches are due half a clock after the edge that enters Update-DR. Each serial bit is on `tdo` from the falling edge of the shift cycle that presents it. The bench therefore drives `tms` and `tdi` one nanosecond after each falling edge and reads `tdo`, `tdo_oe` and the shifted bit in that same slot, before the rising edge that shifts. Decoded outputs are compared only after the task that crosses Update-IR has passed its falling edge. For the timing requirement the bench also reads once between the rising edge into Update-IR and the falling edge that follows it.

// File: rtl/tap_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding, data-register select codes and opcodes
// for the test access port. Assumes a fixed 4-bit instruction.
package tap_ctrl_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET  = 4'hF,
        ST_IDLE   = 4'hC,
        ST_SEL_DR = 4'h7,
        ST_CAP_DR = 4'h6,
        ST_SHF_DR = 4'h2,
        ST_EX1_DR = 4'h1,
        ST_PAU_DR = 4'h3,
        ST_EX2_DR = 4'h0,
        ST_UPD_DR = 4'h5,
        ST_SEL_IR = 4'h4,
        ST_CAP_IR = 4'hE,
        ST_SHF_IR = 4'hA,
        ST_EX1_IR = 4'h9,
        ST_PAU_IR = 4'hB,
        ST_EX2_IR = 4'h8,
        ST_UPD_IR = 4'hD
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS = 2'b00,
        DR_IDENT  = 2'b01,
        DR_BOUND  = 2'b10
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0010;
    localparam logic [IR_W-1:0] OP_FLOATBYP = 4'b0011;
    localparam logic [IR_W-1:0] OP_HOLDBYP  = 4'b0100;
    localparam logic [IR_W-1:0] OP_SELFCHK  = 4'b0101;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
// Module: tap_fsm
// The sixteen-state port controller, advanced on rising tck by tms.
// Assumes trst_n is a synchronous active-low reset sampled on rising tck.
module tap_fsm
    import tap_ctrl_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Purpose: next state from the current state and tms.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
// Module: tap_ir
// Instruction shift stage (rising tck) and active instruction latch
// (falling tck). Assumes the state comes from tap_fsm on the same clock.
module tap_ir
    import tap_ctrl_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_so,
    output logic [IR_W-1:0] instr
);

    logic [IR_W-1:0] sr;

    // Purpose: capture the fixed pattern, then shift toward TDO.
    always_ff @(posedge tck) begin
        if (!trst_n)                 sr <= IR_CAPTURE;
        else if (state == ST_CAP_IR) sr <= IR_CAPTURE;
        else if (state == ST_SHF_IR) sr <= {tdi, sr[IR_W-1:1]};
    end

    // Purpose: load the active instruction on the falling edge in Update-IR.
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) instr <= OP_IDCODE;
        else if (state == ST_UPD_IR)      instr <= sr;
    end

    assign ir_so = sr[0];

endmodule

// File: rtl/tap_bsr.sv
`timescale 1ns/1ps
// Module: tap_bsr
// Generic boundary chain: one shift stage per cell, plus an update latch
// for each cell whose UPD_MASK bit is set. Assumes LEN >= 2.
module tap_bsr #(
    parameter int             LEN      = 99,
    parameter logic [LEN-1:0] UPD_MASK = '1
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tdi,
    input  logic           cap_en,
    input  logic           shf_en,
    input  logic           upd_en,
    input  logic [LEN-1:0] pins_in,
    output logic           so,
    output logic [LEN-1:0] drive
);

    logic [LEN-1:0] sr;

    // Purpose: capture pin values or shift toward TDO on rising tck.
    always_ff @(posedge tck) begin
        if (!trst_n)     sr <= '0;
        else if (cap_en) sr <= pins_in;
        else if (shf_en) sr <= {tdi, sr[LEN-1:1]};
    end

    assign so = sr[0];

    for (genvar g = 0; g < LEN; g++) begin : g_cell
        if (UPD_MASK[g]) begin : g_upd
            logic q;
            // Purpose: update latch for this cell on falling tck.
            always_ff @(negedge tck) begin
                if (!trst_n)     q <= 1'b0;
                else if (upd_en) q <= sr[g];
            end
            assign drive[g] = q;
        end else begin : g_noupd
            assign drive[g] = 1'b0;
        end
    end

endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
// Module: tap_ctrl (top)
// Test access port with instruction decode, bypass, identification and
// boundary registers. Assumes tck is free-running while trst_n is low.
module tap_ctrl
    import tap_ctrl_pkg::*;
#(
    parameter int                 BND_LEN      = 99,
    parameter logic [BND_LEN-1:0] BND_UPD_MASK = '1,
    parameter logic [3:0]         ID_VERSION   = 4'b0011,
    parameter logic [15:0]        ID_PART      = 16'h9400,
    parameter logic [10:0]        ID_MAKER     = 11'd1
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [1:0]         dr_sel,
    output logic               core_hiz,
    output logic               core_hold,
    output logic               selftest_req,
    input  logic [BND_LEN-1:0] bnd_pins_in,
    output logic [BND_LEN-1:0] bnd_drive
);

    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_e      state;
    logic            ir_so;
    logic [IR_W-1:0] instr;
    dr_sel_e         sel;
    logic            bnd_so;
    logic            dr_so;
    logic [ID_W-1:0] id_sr;
    logic            byp_sr;
    logic            tdo_q;
    logic            oe_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir_so  (ir_so),
        .instr  (instr)
    );

    // Purpose: decode the active instruction into selects and requests.
    always_comb begin
        sel          = DR_BYPASS;
        core_hiz     = 1'b0;
        core_hold    = 1'b0;
        selftest_req = 1'b0;
        case (instr)
            OP_EXTEST:   begin sel = DR_BOUND; core_hold = 1'b1; end
            OP_IDCODE:   sel = DR_IDENT;
            OP_SAMPLE:   sel = DR_BOUND;
            OP_FLOATBYP: core_hiz = 1'b1;
            OP_HOLDBYP:  core_hold = 1'b1;
            OP_SELFCHK:  begin sel = DR_BOUND; selftest_req = 1'b1; end
            default:     sel = DR_BYPASS;
        endcase
    end

    assign dr_sel = sel;

    tap_bsr #(
        .LEN      (BND_LEN),
        .UPD_MASK (BND_UPD_MASK)
    ) u_bsr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .cap_en  (state == ST_CAP_DR && sel == DR_BOUND),
        .shf_en  (state == ST_SHF_DR && sel == DR_BOUND),
        .upd_en  (state == ST_UPD_DR && sel == DR_BOUND),
        .pins_in (bnd_pins_in),
        .so      (bnd_so),
        .drive   (bnd_drive)
    );

    // Purpose: identification shift stage, reloaded in Capture-DR.
    always_ff @(posedge tck) begin
        if (!trst_n)
            id_sr <= ID_WORD;
        else if (sel == DR_IDENT && state == ST_CAP_DR)
            id_sr <= ID_WORD;
        else if (sel == DR_IDENT && state == ST_SHF_DR)
            id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Purpose: one-cell bypass register that captures zero.
    always_ff @(posedge tck) begin
        if (!trst_n)
            byp_sr <= 1'b0;
        else if (sel == DR_BYPASS && state == ST_CAP_DR)
            byp_sr <= 1'b0;
        else if (sel == DR_BYPASS && state == ST_SHF_DR)
            byp_sr <= tdi;
    end

    // Purpose: pick the serial output of the selected data register.
    always_comb begin
        case (sel)
            DR_IDENT: dr_so = id_sr[0];
            DR_BOUND: dr_so = bnd_so;
            default:  dr_so = byp_sr;
        endcase
    end

    // Purpose: retime serial out and its enable to the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state == ST_SHF_DR) || (state == ST_SHF_IR);
            if (state == ST_SHF_IR)      tdo_q <= ir_so;
            else if (state == ST_SHF_DR) tdo_q <= dr_so;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/tap_ctrl_props.sv
`timescale 1ns/1ps
// Module: tap_ctrl_props
// Checker bound into tap_ctrl. Assumes trst_n is held low across at
// least one rising and one falling tck edge at start-up.
module tap_ctrl_props
    import tap_ctrl_pkg::*;
#(
    parameter int BND_LEN = 99
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic               tdo_oe,
    input logic [1:0]         dr_sel,
    input logic               core_hiz,
    input logic               core_hold,
    input logic               selftest_req,
    input logic [BND_LEN-1:0] bnd_drive
);

    logic [2:0] tms_run;

    // Purpose: count consecutive rising edges that sampled tms high.
    always_ff @(posedge tck) begin
        if (!trst_n)           tms_run <= '0;
        else if (!tms)         tms_run <= '0;
        else if (tms_run != 5) tms_run <= tms_run + 3'd1;
    end

    assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_RESET));

    assert_reset_clear_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |-> (dr_sel == 2'b01 && !core_hiz && !core_hold && !selftest_req));

    assert_float_excl_R7: assert property (@(posedge tck) disable iff (!trst_n)
        core_hiz |-> (dr_sel == 2'b00 && !core_hold && !selftest_req));

    assert_latch_hold_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_sel != 2'b10) |-> $stable(bnd_drive));

    assert_selftest_bound_R9: assert property (@(posedge tck) disable iff (!trst_n)
        selftest_req |-> (dr_sel == 2'b10));

    assert_instr_stable_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_IR || state == ST_RESET)
            |-> $stable({dr_sel, core_hiz, core_hold, selftest_req}));

    assert_oe_window_R11: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR));

endmodule

bind tap_ctrl tap_ctrl_props #(.BND_LEN(BND_LEN)) u_props (
    .tck          (tck),
    .trst_n       (trst_n),
    .tms          (tms),
    .state        (state),
    .tdo_oe       (tdo_oe),
    .dr_sel       (dr_sel),
    .core_hiz     (core_hiz),
    .core_hold    (core_hold),
    .selftest_req (selftest_req),
    .bnd_drive    (bnd_drive)
);

// File: tb/tap_ctrl_test.sv
`timescale 1ns/1ps
// Bench: sweeps all 16 opcodes on an 8-cell chain, plus reset and timing cases.
module tap_ctrl_test;

    localparam int         LEN  = 8;
    localparam logic [7:0] MASK = 8'b1011_0111;
    localparam logic [31:0] IDW = 32'h3940_0003;
    localparam int         NB   = 40;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, core_hiz, core_hold, selftest_req;
    logic [1:0] dr_sel;
    logic [LEN-1:0] pins = '0, drive;

    int checks = 0, fails = 0;
    bit done = 0;
    logic s_tdo, s_oe;

    tap_ctrl #(.BND_LEN(LEN), .BND_UPD_MASK(MASK)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .dr_sel(dr_sel), .core_hiz(core_hiz),
        .core_hold(core_hold), .selftest_req(selftest_req),
        .bnd_pins_in(pins), .bnd_drive(drive));

    always #2 tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One test clock: drive after falling edge, sample tdo there, then rise.
    task automatic tick(input logic m, input logic d);
        @(negedge tck); #1;
        s_tdo = tdo; s_oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic settle();
        @(negedge tck); #1;
    endtask

    // From Run-Test-Idle: load an instruction, return the captured bits.
    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap, output bit oe_ok);
        oe_ok = 1;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, op[i]);
            cap[i] = s_tdo;
            if (!s_oe) oe_ok = 0;
        end
        tick(1, 0); tick(0, 0);
        #1;
    endtask

    // From Run-Test-Idle: scan NB bits through the data register.
    task automatic scan_dr(input logic [63:0] din, output logic [63:0] dout, output bit oe_ok);
        oe_ok = 1;
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < NB; i++) begin
            tick(i == NB - 1, din[i]);
            dout[i] = s_tdo;
            if (!s_oe) oe_ok = 0;
        end
        tick(1, 0); tick(0, 0);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [3:0] cap;
        logic [63:0] din, dout, exp;
        logic [LEN-1:0] exp_drive;
        bit ok;
        logic [1:0] esel;

        repeat (4) @(posedge tck);
        @(negedge tck); #1;
        trst_n = 1;
        // R1: reset state.
        check(dr_sel == 2'b01 && !core_hiz && !core_hold && !selftest_req, "R1 reset decode",
              {dr_sel, core_hiz, core_hold, selftest_req}, 5'b01000);
        check(drive == '0 && tdo_oe == 0, "R1 reset drive/oe", {drive, tdo_oe}, 0);
        tick(0, 0);
        exp_drive = '0;

        for (int op = 0; op < 16; op++) begin
            pins = LEN'(op * 37 + 5);
            load_ir(4'(op), cap, ok);
            check(cap == 4'b0001, "R2 capture pattern", cap, 4'b0001);
            check(ok, "R11 oe in Shift-IR", ok, 1);
            esel = (op == 1) ? 2'b01 : (op == 0 || op == 2 || op == 5) ? 2'b10 : 2'b00;
            check(dr_sel == esel, "R3 register select", dr_sel, esel);
            check(core_hiz == (op == 3), "R7 float request", core_hiz, (op == 3));
            check(core_hold == (op == 0 || op == 4), "R8 hold request", core_hold, (op == 0 || op == 4));
            check(selftest_req == (op == 5), "R9 self-test request", selftest_req, (op == 5));
            din = {24'h0, 40'(64'hA5C3_1E97_5B ^ (op * 64'h1F3D))};
            scan_dr(din, dout, ok);
            check(ok, "R11 oe in Shift-DR", ok, 1);
            check(tdo_oe == 0, "R11 oe low in idle", tdo_oe, 0);
            for (int i = 0; i < NB; i++) begin
                if (esel == 2'b01)      exp[i] = (i < 32) ? IDW[i] : din[i - 32];
                else if (esel == 2'b10) exp[i] = (i < LEN) ? pins[i] : din[i - LEN];
                else                    exp[i] = (i == 0) ? 1'b0 : din[i - 1];
            end
            exp[63:NB] = '0;
            if (esel == 2'b01)      check(dout == exp, "R4 ident scan", dout, exp);
            else if (esel == 2'b10) check(dout == exp, "R6 boundary scan", dout, exp);
            else                    check(dout == exp, "R5 bypass scan", dout, exp);
            if (esel == 2'b10) exp_drive = din[NB-1 -: LEN] & MASK;
            if (esel == 2'b10) check(drive == exp_drive, "R6 update latches", drive, exp_drive);
            else               check(drive == exp_drive, "R8 latches unchanged", drive, exp_drive);
        end

        // R10: new instruction is not active on the rising edge into Update-IR.
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(i == 3, (i == 0 || i == 1));
        tick(1, 0);
        #1;
        check(dr_sel == 2'b00 && !core_hiz, "R10 old instr at Update-IR entry", {dr_sel, core_hiz}, 3'b000);
        settle();
        check(dr_sel == 2'b00 && core_hiz, "R10 new instr after falling edge", {dr_sel, core_hiz}, 3'b001);
        tms = 0;
        @(posedge tck);

        // R1: five tms-high clocks from Shift-DR, latches kept.
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        settle();
        check(dr_sel == 2'b01 && !core_hiz, "R1 tms reset from Shift-DR", {dr_sel, core_hiz}, 3'b010);
        check(drive == exp_drive, "R1 tms reset keeps latches", drive, exp_drive);
        tms = 0;
        @(posedge tck);

        // R1: five tms-high clocks from Shift-IR after loading HOLDBYP.
        load_ir(4'b0100, cap, ok);
        check(core_hold, "R8 hold loaded", core_hold, 1);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        settle();
        check(dr_sel == 2'b01 && !core_hold, "R1 tms reset from Shift-IR", {dr_sel, core_hold}, 3'b010);
        tms = 0;
        @(posedge tck);

        // R1: trst_n during FLOATBYP clears requests and latches.
        load_ir(4'b0011, cap, ok);
        @(negedge tck); #1;
        trst_n = 0;
        @(posedge tck);
        settle();
        trst_n = 1;
        check(dr_sel == 2'b01 && !core_hiz && drive == '0, "R1 trst_n clear",
              {drive, dr_sel, core_hiz}, 11'b010);
        finish_run();
    end

endmodule